// File: doc/BRIEF.md
# Supply-Fail Write-Protect Sequencer

This block is the control logic for a battery-backed byte-wide memory. Once per clock it reads a digitized supply level as an unsigned millivolt code. From that level it decides whether the memory may be read and written, or whether it must be fenced off. While fenced off, writes are blocked, control and address inputs are ignored and the data outputs float. It also decides whether the memory core is fed from the external rail or from its backup cell.

The block leaves reset in a shipping-seal state. In that state the backup cell stays disconnected, however low the supply goes. The seal breaks permanently the first time the supply rises past the protect trip point. A single select input, captured only while reset is held, picks one of two threshold sets. All thresholds and the hysteresis margin are parameters.

Every output is a registered decode of the state. An output therefore reflects the supply sample taken at the previous clock edge.

Top module: `supply_guard_seq`

## Requirements
- R1: While reset is low and in the first cycle after it, the block is sealed: `wr_block_o`, `in_ignore_o` and `out_hiz_o` are 1 and `backup_sel_o` is 0. Each output follows the supply sample of the previous rising edge (one cycle of latency).
- R2: `variant_sel_i` is captured only while `rst_n` is low. Value 0 selects full-operation level 4750 mV with trip point 4500 mV. Value 1 selects 4500 mV with trip point 4250 mV. Changing the input after reset has no effect on any output.
- R3: When sealed, the first sample strictly above the trip point moves the block to the protected state. A sample equal to the trip point keeps it sealed. The seal never returns without a reset.
- R4: While sealed, a sample below 3000 mV leaves `backup_sel_o` at 0.
- R5: In the protected state, a sample strictly above the full-operation level moves the block to active, where all three protect flags are 0. A sample equal to that level keeps it protected.
- R6: In the active state, a sample below (full-operation level − 20 mV) moves the block to protected. Samples from that value up to the full-operation level keep it active.
- R7: From protected or active, a sample below 3000 mV selects the backup cell at the next edge. This happens directly from active, in one cycle, with the protect flags set in that same cycle.
- R8: With the backup selected, a sample strictly above 3020 mV returns the block to protected (backup released). Samples from 3000 to 3020 mV keep the backup selected.
- R9: The three protect flags are always equal and are 1 in every state but active. `backup_sel_o` is 1 only in the backup state, and never while the protect flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| variant_sel_i | input | 1 | Threshold set select, captured during reset |
| supply_mv_i | input | 13 | Supply sample in millivolts, unsigned |
| wr_block_o | output | 1 | Writes to the memory are blocked |
| in_ignore_o | output | 1 | Control and address inputs are treated as don't-care |
| out_hiz_o | output | 1 | Data outputs are high-impedance |
| backup_sel_o | output | 1 | Memory core runs from the backup cell |

## Verification
Write protection and backup switchover can be decided on the same edge. This happens when an active block sees a single sample that falls straight from above the full-operation level to below 3000 mV. The bench drives that drop from active with no intermediate sample. Its reference model requires the protect flags and `backup_sel_o` to change together at the following edge. A second coincidence is driven while sealed: a collapse below 3000 mV must leave the backup deselected even though the backup threshold is crossed.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;

   typedef enum logic [1:0] {
      GS_SEALED     = 2'd0,
      GS_OFF_BACKUP = 2'd1,
      GS_PROTECTED  = 2'd2,
      GS_ACTIVE     = 2'd3
   } guard_state_t;

   typedef struct packed {
      logic over_trip;
      logic over_full;
      logic under_hold;
      logic under_switch;
      logic over_rejoin;
   } level_flags_t;

endpackage

// File: rtl/supply_guard_thresh.sv
module supply_guard_thresh #(
   parameter int CODE_W     = 13,
   parameter bit ALT_EN     = 1'b1,
   parameter int A_FULL_MV  = 4750,
   parameter int A_TRIP_MV  = 4500,
   parameter int B_FULL_MV  = 4500,
   parameter int B_TRIP_MV  = 4250,
   parameter int SWITCH_MV  = 3000,
   parameter int HYST_MV    = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              variant_sel_i,
   output logic [CODE_W-1:0] full_mv_o,
   output logic [CODE_W-1:0] trip_mv_o,
   output logic [CODE_W-1:0] hold_mv_o,
   output logic [CODE_W-1:0] switch_mv_o,
   output logic [CODE_W-1:0] rejoin_mv_o
);

   localparam logic [CODE_W-1:0] A_FULL = CODE_W'(A_FULL_MV);
   localparam logic [CODE_W-1:0] A_TRIP = CODE_W'(A_TRIP_MV);
   localparam logic [CODE_W-1:0] A_HOLD = CODE_W'(A_FULL_MV - HYST_MV);
   localparam logic [CODE_W-1:0] B_FULL = CODE_W'(B_FULL_MV);
   localparam logic [CODE_W-1:0] B_TRIP = CODE_W'(B_TRIP_MV);
   localparam logic [CODE_W-1:0] B_HOLD = CODE_W'(B_FULL_MV - HYST_MV);
   localparam logic [CODE_W-1:0] SW     = CODE_W'(SWITCH_MV);
   localparam logic [CODE_W-1:0] REJOIN = CODE_W'(SWITCH_MV + HYST_MV);

   logic use_b;

   generate
      if (ALT_EN) begin : g_alt
         logic var_q;
         always_ff @(posedge clk) begin
            if (!rst_n) var_q <= variant_sel_i;
         end
         assign use_b = var_q;
      end else begin : g_fixed
         logic unused_sel;
         assign unused_sel = variant_sel_i ^ clk ^ rst_n;
         assign use_b      = 1'b0;
      end
   endgenerate

   always_comb begin
      full_mv_o   = use_b ? B_FULL : A_FULL;
      trip_mv_o   = use_b ? B_TRIP : A_TRIP;
      hold_mv_o   = use_b ? B_HOLD : A_HOLD;
      switch_mv_o = SW;
      rejoin_mv_o = REJOIN;
   end

endmodule

// File: rtl/supply_guard_cmp.sv
module supply_guard_cmp
   import supply_guard_pkg::*;
#(
   parameter int CODE_W = 13
) (
   input  logic [CODE_W-1:0] supply_mv_i,
   input  logic [CODE_W-1:0] full_mv_i,
   input  logic [CODE_W-1:0] trip_mv_i,
   input  logic [CODE_W-1:0] hold_mv_i,
   input  logic [CODE_W-1:0] switch_mv_i,
   input  logic [CODE_W-1:0] rejoin_mv_i,
   output level_flags_t      flags_o
);

   always_comb begin
      flags_o.over_trip    = supply_mv_i > trip_mv_i;
      flags_o.over_full    = supply_mv_i > full_mv_i;
      flags_o.under_hold   = supply_mv_i < hold_mv_i;
      flags_o.under_switch = supply_mv_i < switch_mv_i;
      flags_o.over_rejoin  = supply_mv_i > rejoin_mv_i;
   end

endmodule

// File: rtl/supply_guard_fsm.sv
module supply_guard_fsm
   import supply_guard_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  level_flags_t flags_i,
   output logic         wr_block_o,
   output logic         in_ignore_o,
   output logic         out_hiz_o,
   output logic         backup_sel_o
);

   guard_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         GS_SEALED: begin
            if (flags_i.over_trip) state_d = GS_PROTECTED;
         end
         GS_PROTECTED: begin
            if (flags_i.under_switch)   state_d = GS_OFF_BACKUP;
            else if (flags_i.over_full) state_d = GS_ACTIVE;
         end
         GS_ACTIVE: begin
            if (flags_i.under_switch)    state_d = GS_OFF_BACKUP;
            else if (flags_i.under_hold) state_d = GS_PROTECTED;
         end
         GS_OFF_BACKUP: begin
            if (flags_i.over_rejoin) state_d = GS_PROTECTED;
         end
         default: state_d = GS_SEALED;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= GS_SEALED;
      else        state_q <= state_d;
   end

   always_comb begin
      wr_block_o   = (state_q != GS_ACTIVE);
      in_ignore_o  = (state_q != GS_ACTIVE);
      out_hiz_o    = (state_q != GS_ACTIVE);
      backup_sel_o = (state_q == GS_OFF_BACKUP);
   end

endmodule

// File: rtl/supply_guard_seq.sv
module supply_guard_seq
   import supply_guard_pkg::*;
#(
   parameter int CODE_W    = 13,
   parameter bit ALT_EN    = 1'b1,
   parameter int A_FULL_MV = 4750,
   parameter int A_TRIP_MV = 4500,
   parameter int B_FULL_MV = 4500,
   parameter int B_TRIP_MV = 4250,
   parameter int SWITCH_MV = 3000,
   parameter int HYST_MV   = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              variant_sel_i,
   input  logic [CODE_W-1:0] supply_mv_i,
   output logic              wr_block_o,
   output logic              in_ignore_o,
   output logic              out_hiz_o,
   output logic              backup_sel_o
);

   localparam int CODE_MAX = (1 << CODE_W) - 1;

   initial begin
      assert (HYST_MV >= 0 && HYST_MV < A_FULL_MV - A_TRIP_MV && HYST_MV < B_FULL_MV - B_TRIP_MV)
         else $fatal(1, "hysteresis must fit between full and trip levels");
      assert (SWITCH_MV + HYST_MV < A_TRIP_MV && SWITCH_MV + HYST_MV < B_TRIP_MV)
         else $fatal(1, "switchover band must lie below the trip points");
      assert (A_FULL_MV <= CODE_MAX && B_FULL_MV <= CODE_MAX)
         else $fatal(1, "CODE_W too narrow for the thresholds");
   end

   logic [CODE_W-1:0] full_mv, trip_mv, hold_mv, switch_mv, rejoin_mv;
   level_flags_t      flags;

   supply_guard_thresh #(
      .CODE_W(CODE_W), .ALT_EN(ALT_EN),
      .A_FULL_MV(A_FULL_MV), .A_TRIP_MV(A_TRIP_MV),
      .B_FULL_MV(B_FULL_MV), .B_TRIP_MV(B_TRIP_MV),
      .SWITCH_MV(SWITCH_MV), .HYST_MV(HYST_MV)
   ) u_thresh (
      .clk          (clk),
      .rst_n        (rst_n),
      .variant_sel_i(variant_sel_i),
      .full_mv_o    (full_mv),
      .trip_mv_o    (trip_mv),
      .hold_mv_o    (hold_mv),
      .switch_mv_o  (switch_mv),
      .rejoin_mv_o  (rejoin_mv)
   );

   supply_guard_cmp #(.CODE_W(CODE_W)) u_cmp (
      .supply_mv_i(supply_mv_i),
      .full_mv_i  (full_mv),
      .trip_mv_i  (trip_mv),
      .hold_mv_i  (hold_mv),
      .switch_mv_i(switch_mv),
      .rejoin_mv_i(rejoin_mv),
      .flags_o    (flags)
   );

   supply_guard_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .flags_i     (flags),
      .wr_block_o  (wr_block_o),
      .in_ignore_o (in_ignore_o),
      .out_hiz_o   (out_hiz_o),
      .backup_sel_o(backup_sel_o)
   );

endmodule

// File: rtl/supply_guard_chk.sv
module supply_guard_chk #(
   parameter int CODE_W = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CODE_W-1:0] supply_mv_i,
   input logic [CODE_W-1:0] full_mv,
   input logic [CODE_W-1:0] trip_mv,
   input logic [CODE_W-1:0] hold_mv,
   input logic [CODE_W-1:0] switch_mv,
   input logic [CODE_W-1:0] rejoin_mv,
   input logic              wr_block_o,
   input logic              in_ignore_o,
   input logic              out_hiz_o,
   input logic              backup_sel_o
);

   logic armed_q;

   always_ff @(posedge clk) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= armed_q | (supply_mv_i > trip_mv);
   end

   // R4: no backup before the seal was broken by a sample above the trip point
   p_seal_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_q |-> !backup_sel_o);

   // R5: protect flags drop only after a sample above the full-operation level
   p_active_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_block_o) |-> ($past(supply_mv_i) > $past(full_mv)));

   // R6: leaving active needs a sample below the hold level or the switch level
   p_active_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_block_o) |-> ($past(supply_mv_i) < $past(hold_mv)));

   // R7: backup is selected only after a sample below the switch level
   p_backup_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(backup_sel_o) |-> ($past(supply_mv_i) < $past(switch_mv)));

   // R8: backup is released only after a sample above the rejoin level
   p_backup_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(backup_sel_o) |-> ($past(supply_mv_i) > $past(rejoin_mv)));

   // R9: the backup cell never feeds an unprotected memory; flags agree
   p_backup_protected_r9: assert property (@(posedge clk) disable iff (!rst_n)
      backup_sel_o |-> (wr_block_o && in_ignore_o && out_hiz_o));

   p_flags_agree_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_block_o == in_ignore_o) && (wr_block_o == out_hiz_o));

endmodule

bind supply_guard_seq supply_guard_chk #(.CODE_W(CODE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .supply_mv_i (supply_mv_i),
   .full_mv     (full_mv),
   .trip_mv     (trip_mv),
   .hold_mv     (hold_mv),
   .switch_mv   (switch_mv),
   .rejoin_mv   (rejoin_mv),
   .wr_block_o  (wr_block_o),
   .in_ignore_o (in_ignore_o),
   .out_hiz_o   (out_hiz_o),
   .backup_sel_o(backup_sel_o)
);

// File: tb/test_supply_guard_seq.sv
module test_supply_guard_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        variant_sel = 1'b0;
   logic [12:0] supply = '0;
   logic        wr_block, in_ignore, out_hiz, backup_sel;

   int n_checks = 0;
   int n_fail   = 0;

   // model: 0 sealed, 1 backup, 2 protected, 3 active
   int m_st  = 0;
   int m_var = 0;

   always #4 clk = ~clk;

   supply_guard_seq i_supply_guard_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .variant_sel_i(variant_sel),
      .supply_mv_i  (supply),
      .wr_block_o   (wr_block),
      .in_ignore_o  (in_ignore),
      .out_hiz_o    (out_hiz),
      .backup_sel_o (backup_sel)
   );

   function automatic int full_lvl();  return (m_var != 0) ? 4500 : 4750; endfunction
   function automatic int trip_lvl();  return (m_var != 0) ? 4250 : 4500; endfunction

   function automatic void model_next(int v);
      case (m_st)
         0: if (v > trip_lvl()) m_st = 2;
         2: if (v < 3000) m_st = 1; else if (v > full_lvl()) m_st = 3;
         3: if (v < 3000) m_st = 1; else if (v < full_lvl() - 20) m_st = 2;
         1: if (v > 3020) m_st = 1 + 1;
         default: m_st = 0;
      endcase
   endfunction

   task automatic compare(string tag);
      logic [3:0] got, exp;
      logic       p;
      p   = (m_st != 3);
      exp = {p, p, p, (m_st == 1)};
      got = {wr_block, in_ignore, out_hiz, backup_sel};
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: {wr,ign,hiz,bk} actual %b expected %b (model state %0d)",
                  tag, got, exp, m_st);
      end
   endtask

   // compare the current outputs, then apply the next sample
   task automatic step(int v, string tag);
      @(negedge clk);
      compare(tag);
      supply = 13'(v);
      model_next(v);
   endtask

   task automatic do_reset(bit vs);
      @(negedge clk);
      rst_n       = 1'b0;
      variant_sel = vs;
      supply      = '0;
      m_st        = 0;
      m_var       = vs;
      repeat (2) @(negedge clk);
      compare("R1 in reset");
      rst_n = 1'b1;
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin : stim
      // variant 0
      do_reset(1'b0);
      step(0,    "R1 after reset");
      step(2000, "R1 sealed");
      step(100,  "R4 sealed collapse");
      step(4500, "R4 sealed low");
      step(4501, "R3 at trip stays sealed");
      step(4600, "R3 seal broken");
      step(2000, "R3 protected");
      step(3000, "R7 backup entry");
      step(3020, "R8 backup held");
      step(3021, "R8 backup held at rejoin");
      step(4750, "R8 released");
      step(4751, "R5 at full stays protected");
      variant_sel = 1'b1;
      step(4600, "R5 active entry");
      step(4730, "R2 variant change ignored");
      step(4729, "R6 hold band");
      step(4800, "R6 active exit");
      step(4800, "R6 protected");
      step(1000, "R5 active again");
      step(4000, "R7 active straight to backup");
      step(5000, "R8 backup band");
      step(5000, "R3 seal not restored");
      step(5000, "R5 active");

      // variant 1
      do_reset(1'b1);
      step(100,  "R1 after reset variant 1");
      step(4250, "R4 sealed collapse variant 1");
      step(4251, "R2 at trip stays sealed");
      step(4500, "R2 seal broken at lower trip");
      step(4501, "R2 at lower full stays protected");
      variant_sel = 1'b0;
      step(4480, "R2 active at lower full");
      step(4479, "R6 hold band variant 1");
      step(2999, "R6 exit variant 1");
      step(2999, "R7 backup variant 1");
      step(0,    "R9 backup only flag");
      step(0,    "R9 final");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule